// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Loader

This block loads a configuration image into a downstream FPGA through a three-wire serial interface. A start pulse runs the target's reset handshake. The block drives the target's active-low reset line low, waits for the target's init line to fall, then releases reset and waits for init to rise again. Each of these waits is checked on a slow poll tick of about one millisecond, which comes from a clock-frequency parameter. If a wait runs out of polls, the block stops with its own error code.

Once the target is ready, the block takes image bytes from a valid/ready stream with a last flag. It discards bytes until it finds a synchronisation pattern, and the pattern depends on the mode input. It then sends a header, the payload and, in raw mode, trailing padding, one bit at a time with the most significant bit first. Finally it polls the target's done line and reports success or a failure code. Expanding compressed payloads is handled elsewhere. This block only frames compressed data with its own sync pattern and literal header.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, tgt_reset_n, tgt_clk and tgt_data are 1, busy, done_ok and cfg_ready are 0, and err_code is 0 (0 means no error).
- R2: A start pulse makes busy 1 and drives tgt_reset_n to 0 on the next clock edge. While tgt_reset_n is 0, tgt_clk and tgt_data both stay 1.
- R3: In the reset phase, tgt_init_n is sampled on every poll tick. If the fourth consecutive poll still sees it high, the run ends with err_code 1, busy 0 and tgt_reset_n 1.
- R4: Once init is seen low, tgt_reset_n returns to 1 and the block polls for init going high. If the fourth consecutive poll still sees it low, the run ends with err_code 2.
- R5: Each byte is sent most significant bit first. For each bit, tgt_clk goes low with tgt_data high, then tgt_data takes the bit, then tgt_clk rises with the bit held. tgt_data returns to 1 before the next fall of tgt_clk.
- R6: In raw mode (compressed = 0), input bytes are discarded until the first run of four consecutive 0xFF bytes. Those four 0xFF bytes are the first ones sent, and any shorter run of 0xFF is discarded.
- R7: In raw mode, eight 0xFF bytes are sent after the byte that carries cfg_last.
- R8: In compressed mode (compressed = 1), bytes are discarded until a 0xFF byte is directly followed by a byte whose upper nibble is 3. Neither byte is sent. Instead 0xFF and 0x20 are sent, followed by the bytes after the pair, with no trailing padding.
- R9: After the last bit, tgt_done is polled. If it is seen high, the run ends with done_ok 1 and err_code 0. If the fourth consecutive poll sees it low, the run ends with err_code 3.
- R10: cfg_ready is 1 only while busy, during the sync search or while the serialiser is free to accept a payload byte.
- R11: A start pulse during a run abandons it at once and starts a new run in the mode then present on compressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins or restarts a run |
| compressed | input | 1 | Mode, sampled on start: 1 compressed framing, 0 raw |
| cfg_valid | input | 1 | Image byte valid |
| cfg_data | input | 8 | Image byte |
| cfg_last | input | 1 | Marks the final image byte |
| cfg_ready | output | 1 | Block accepts the image byte this cycle |
| tgt_init_n | input | 1 | Target init line (active low) |
| tgt_done | input | 1 | Target configuration done line |
| tgt_reset_n | output | 1 | Target reset/program line (active low) |
| tgt_clk | output | 1 | Serial configuration clock |
| tgt_data | output | 1 | Serial configuration data |
| busy | output | 1 | A run is in progress |
| done_ok | output | 1 | Last run finished successfully |
| err_code | output | 2 | 0 none, 1 init stuck high, 2 init stuck low, 3 done missing |

## Verification
On every cycle, the assertions check the serial-line discipline: data is stable when the clock rises, and data is high when the clock falls. They also check that clock and data stay idle-high while the target is held in reset, that ready is never raised outside a run, that success and error never appear together, and that a start pulse always leads into the reset phase. Only the directed scenarios can show the rest. That covers which bytes the sync search discards, the exact header, payload and padding sequence in each mode, the number of polls before each of the three timeouts, and that a restart abandons a half-sent stream.

// File: rtl/serial_cfg_loader_pkg.sv
package serial_cfg_loader_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_HOLD,
    ST_INIT_RISE,
    ST_SYNC,
    ST_HEADER,
    ST_PAYLOAD,
    ST_PAD,
    ST_DRAIN,
    ST_DONE_WAIT
  } ld_state_t;

  localparam logic [1:0] ERR_NONE      = 2'd0;
  localparam logic [1:0] ERR_INIT_HIGH = 2'd1;
  localparam logic [1:0] ERR_INIT_LOW  = 2'd2;
  localparam logic [1:0] ERR_NO_DONE   = 2'd3;

  localparam logic [7:0] BYTE_ONES = 8'hFF;
  localparam logic [7:0] CMP_TAG   = 8'h20;
  localparam logic [3:0] CMP_NIB   = 4'h3;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_poll_timer.sv
module cfg_poll_timer #(
  parameter int PERIOD = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !clr;

  if (PERIOD > 1) begin : g_chk
    // R3: poll ticks are isolated single-cycle events
    a_r3_tick_isolated: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
  end
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       load,
  input  logic [7:0] byte_in,
  output logic       busy,
  output logic       sclk,
  output logic       sdat
);
  logic       active;
  logic [7:0] sreg;
  logic [2:0] bit_cnt;
  logic [1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active  <= 1'b0;
      sreg    <= '0;
      bit_cnt <= '0;
      phase   <= '0;
      sclk    <= 1'b1;
      sdat    <= 1'b1;
    end else if (!active) begin
      if (load) begin
        active  <= 1'b1;
        sreg    <= byte_in;
        bit_cnt <= '0;
        phase   <= 2'd0;
        sclk    <= 1'b0;
        sdat    <= 1'b1;
      end
    end else begin
      unique case (phase)
        2'd0: begin sdat <= sreg[7]; phase <= 2'd1; end
        2'd1: begin sclk <= 1'b1;    phase <= 2'd2; end
        2'd2: begin sdat <= 1'b1;    phase <= 2'd3; end
        default: begin
          if (bit_cnt == 3'd7) begin
            active <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sreg    <= {sreg[6:0], 1'b0};
            sclk    <= 1'b0;
            phase   <= 2'd0;
          end
        end
      endcase
    end
  end

  assign busy = active;

  // R5: data does not move while the clock rises
  a_r5_data_stable_rise: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && !$past(abort) && !$past(rst)) |-> $stable(sdat));
  // R5: data is high whenever the clock falls
  a_r5_data_high_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> sdat);
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_loader_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int POLL_HZ     = 1000,
  parameter int MAX_MISSES  = 3,
  parameter int SYNC_FF_LEN = 4,
  parameter int PAD_BYTES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       compressed,
  input  logic       cfg_valid,
  input  logic [7:0] cfg_data,
  input  logic       cfg_last,
  output logic       cfg_ready,
  input  logic       tgt_init_n,
  input  logic       tgt_done,
  output logic       tgt_reset_n,
  output logic       tgt_clk,
  output logic       tgt_data,
  output logic       busy,
  output logic       done_ok,
  output logic [1:0] err_code
);
  localparam int POLL_CYC = (CLK_HZ / POLL_HZ > 1) ? CLK_HZ / POLL_HZ : 1;
  localparam int MW = $clog2(MAX_MISSES + 1);
  localparam int HW = (SYNC_FF_LEN > 1) ? $clog2(SYNC_FF_LEN) : 1;
  localparam int PW = (PAD_BYTES > 1) ? $clog2(PAD_BYTES) : 1;
  localparam logic [MW-1:0] MISS_LIM  = MW'(MAX_MISSES);
  localparam logic [HW-1:0] RAW_LAST  = HW'(SYNC_FF_LEN - 1);
  localparam logic [HW-1:0] CMP_LAST  = HW'(1);
  localparam logic [PW-1:0] PAD_LAST  = PW'(PAD_BYTES - 1);

  ld_state_t       state;
  logic            mode_q;
  logic [MW-1:0]   miss;
  logic [HW-1:0]   ff_run;
  logic            prev_ff;
  logic [HW-1:0]   hdr_idx;
  logic [PW-1:0]   pad_cnt;
  logic            last_seen;

  logic init_s, done_s, tick, waiting, tmr_clr;
  logic sh_busy, sh_load;
  logic [7:0] sh_byte;
  logic byte_take, is_ones, cmp_hit;

  cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
    .clk(clk), .rst(rst), .d(tgt_init_n), .q(init_s));
  cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
    .clk(clk), .rst(rst), .d(tgt_done), .q(done_s));

  assign waiting = (state == ST_RST_HOLD) || (state == ST_INIT_RISE) ||
                   (state == ST_DONE_WAIT);
  assign tmr_clr = start || !waiting;

  cfg_poll_timer #(.PERIOD(POLL_CYC)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick));

  always_comb begin
    sh_load = 1'b0;
    sh_byte = BYTE_ONES;
    unique case (state)
      ST_HEADER: begin
        sh_load = !sh_busy;
        sh_byte = (mode_q && hdr_idx == CMP_LAST) ? CMP_TAG : BYTE_ONES;
      end
      ST_PAYLOAD: begin
        sh_load = cfg_valid && !sh_busy;
        sh_byte = cfg_data;
      end
      ST_PAD: sh_load = !sh_busy;
      default: ;
    endcase
  end

  cfg_bit_shifter u_shift (
    .clk(clk), .rst(rst), .abort(start), .load(sh_load && !start),
    .byte_in(sh_byte), .busy(sh_busy), .sclk(tgt_clk), .sdat(tgt_data));

  assign cfg_ready = (state == ST_SYNC) || (state == ST_PAYLOAD && !sh_busy);
  assign byte_take = cfg_valid && cfg_ready;
  assign is_ones   = (cfg_data == BYTE_ONES);
  assign cmp_hit   = prev_ff && (cfg_data[7:4] == CMP_NIB);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mode_q      <= 1'b0;
      miss        <= '0;
      ff_run      <= '0;
      prev_ff     <= 1'b0;
      hdr_idx     <= '0;
      pad_cnt     <= '0;
      last_seen   <= 1'b0;
      tgt_reset_n <= 1'b1;
      busy        <= 1'b0;
      done_ok     <= 1'b0;
      err_code    <= ERR_NONE;
    end else if (start) begin
      state       <= ST_RST_HOLD;
      mode_q      <= compressed;
      miss        <= '0;
      ff_run      <= '0;
      prev_ff     <= 1'b0;
      hdr_idx     <= '0;
      pad_cnt     <= '0;
      last_seen   <= 1'b0;
      tgt_reset_n <= 1'b0;
      busy        <= 1'b1;
      done_ok     <= 1'b0;
      err_code    <= ERR_NONE;
    end else begin
      unique case (state)
        ST_RST_HOLD: if (tick) begin
          if (!init_s) begin
            state       <= ST_INIT_RISE;
            tgt_reset_n <= 1'b1;
            miss        <= '0;
          end else if (miss == MISS_LIM) begin
            state       <= ST_IDLE;
            tgt_reset_n <= 1'b1;
            busy        <= 1'b0;
            err_code    <= ERR_INIT_HIGH;
          end else begin
            miss <= miss + 1'b1;
          end
        end
        ST_INIT_RISE: if (tick) begin
          if (init_s) begin
            state <= ST_SYNC;
            miss  <= '0;
          end else if (miss == MISS_LIM) begin
            state    <= ST_IDLE;
            busy     <= 1'b0;
            err_code <= ERR_INIT_LOW;
          end else begin
            miss <= miss + 1'b1;
          end
        end
        ST_SYNC: if (byte_take) begin
          if (mode_q) begin
            prev_ff <= is_ones;
            if (cmp_hit) begin
              state     <= ST_HEADER;
              hdr_idx   <= '0;
              last_seen <= cfg_last;
            end
          end else if (is_ones) begin
            if (ff_run == RAW_LAST) begin
              state     <= ST_HEADER;
              hdr_idx   <= '0;
              last_seen <= cfg_last;
            end else begin
              ff_run <= ff_run + 1'b1;
            end
          end else begin
            ff_run <= '0;
          end
        end
        ST_HEADER: if (sh_load) begin
          if (hdr_idx == (mode_q ? CMP_LAST : RAW_LAST)) begin
            pad_cnt <= '0;
            if (!last_seen)  state <= ST_PAYLOAD;
            else if (mode_q) state <= ST_DRAIN;
            else             state <= ST_PAD;
          end else begin
            hdr_idx <= hdr_idx + 1'b1;
          end
        end
        ST_PAYLOAD: if (sh_load && cfg_last) begin
          pad_cnt <= '0;
          state   <= mode_q ? ST_DRAIN : ST_PAD;
        end
        ST_PAD: if (sh_load) begin
          if (pad_cnt == PAD_LAST) state <= ST_DRAIN;
          else                     pad_cnt <= pad_cnt + 1'b1;
        end
        ST_DRAIN: if (!sh_busy) begin
          state <= ST_DONE_WAIT;
          miss  <= '0;
        end
        ST_DONE_WAIT: if (tick) begin
          if (done_s) begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            done_ok <= 1'b1;
          end else if (miss == MISS_LIM) begin
            state    <= ST_IDLE;
            busy     <= 1'b0;
            err_code <= ERR_NO_DONE;
          end else begin
            miss <= miss + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: serial lines idle high while the target is held in reset
  a_r2_lines_idle_in_reset: assert property (@(posedge clk) disable iff (rst)
    !tgt_reset_n |-> (tgt_clk && tgt_data && busy));
  // R10: byte acceptance only inside a run
  a_r10_ready_needs_busy: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |-> busy);
  // R9: success and error are exclusive
  a_r9_ok_excludes_err: assert property (@(posedge clk) disable iff (rst)
    done_ok |-> (err_code == ERR_NONE && !busy));
  // R3: any error ends the run with the target released
  a_r3_err_ends_run: assert property (@(posedge clk) disable iff (rst)
    (err_code != ERR_NONE) |-> (!busy && tgt_reset_n));
  // R11: a start pulse always re-enters the reset phase
  a_r11_start_restarts: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && !tgt_reset_n && err_code == ERR_NONE));
endmodule

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
  localparam int P = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, compressed = 1'b0;
  logic cfg_valid = 1'b0, cfg_last = 1'b0;
  logic [7:0] cfg_data = '0;
  logic cfg_ready;
  logic tgt_init_n = 1'b1, tgt_done = 1'b0;
  logic tgt_reset_n, tgt_clk, tgt_data, busy, done_ok;
  logic [1:0] err_code;

  always #2.5 clk = ~clk;

  serial_cfg_loader #(.CLK_HZ(P * 1000), .POLL_HZ(1000)) dut_i (
    .clk(clk), .rst(rst), .start(start), .compressed(compressed),
    .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_last(cfg_last),
    .cfg_ready(cfg_ready), .tgt_init_n(tgt_init_n), .tgt_done(tgt_done),
    .tgt_reset_n(tgt_reset_n), .tgt_clk(tgt_clk), .tgt_data(tgt_data),
    .busy(busy), .done_ok(done_ok), .err_code(err_code));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit reported = 0;

  // target model and serial capture
  bit low_ok = 0, high_ok = 0;
  int done_at = -1, nbits = 0, cap_n = 0, fall_bad = 0;
  logic [7:0] acc = '0;
  logic [7:0] cap [0:63];
  logic clk_prev = 1'b1;

  always @(negedge clk) begin
    if (!tgt_reset_n) begin
      if (low_ok) tgt_init_n = 1'b0;
    end else if (high_ok) tgt_init_n = 1'b1;
    if (tgt_clk && !clk_prev) begin
      acc = {acc[6:0], tgt_data};
      nbits++;
      if (nbits % 8 == 0 && cap_n < 64) begin cap[cap_n] = acc; cap_n++; end
      if (nbits == done_at) tgt_done = 1'b1;
    end
    if (!tgt_clk && clk_prev && !tgt_data) fall_bad++;
    clk_prev = tgt_clk;
  end

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_stream(string req, logic [7:0] exp[$]);
    check({req, " byte count"}, cap_n, exp.size());
    for (int i = 0; i < exp.size() && i < cap_n; i++)
      check($sformatf("%s byte %0d", req, i), cap[i], exp[i]);
    check({req, " data high at clock fall"}, fall_bad, 0);
  endtask

  task automatic start_run(bit m, bit lo, bit hi, int dbits);
    @(negedge clk); start = 1'b1; compressed = m;
    @(negedge clk); start = 1'b0;
    @(posedge clk);
    low_ok = lo; high_ok = hi; done_at = dbits; tgt_done = 1'b0;
    nbits = 0; cap_n = 0; fall_bad = 0;
    @(negedge clk);
  endtask

  task automatic push(logic [7:0] b, bit last);
    cfg_valid = 1'b1; cfg_data = b; cfg_last = last;
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1'b0; cfg_last = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset_n", tgt_reset_n, 1);
    check("R1 clk", tgt_clk, 1);
    check("R1 data", tgt_data, 1);
    check("R1 busy", busy, 0);
    check("R1 done_ok", done_ok, 0);
    check("R1 err", err_code, 0);
    check("R1 ready", cfg_ready, 0);
  endtask

  task automatic t_init_stuck_high();
    @(negedge clk); start = 1'b1; compressed = 1'b0; low_ok = 0; high_ok = 0;
    @(negedge clk); start = 1'b0;
    check("R2 reset_n low", tgt_reset_n, 0);
    check("R2 busy", busy, 1);
    check("R2 clk high", tgt_clk, 1);
    check("R2 data high", tgt_data, 1);
    check("R10 ready in reset phase", cfg_ready, 0);
    repeat (3 * P + P / 2 - 1) @(negedge clk);
    check("R3 no error after three polls", err_code, 0);
    check("R3 still busy after three polls", busy, 1);
    repeat (P) @(negedge clk);
    check("R3 err code 1", err_code, 1);
    check("R3 busy cleared", busy, 0);
    check("R3 reset released", tgt_reset_n, 1);
  endtask

  task automatic t_init_stuck_low();
    start_run(0, 1, 0, -1);
    repeat (8 * P) @(negedge clk);
    check("R4 err code 2", err_code, 2);
    check("R4 busy cleared", busy, 0);
    check("R4 reset released", tgt_reset_n, 1);
  endtask

  task automatic t_raw();
    logic [7:0] exp[$];
    start_run(0, 1, 1, 15 * 8);
    push(8'h12, 0); push(8'h34, 0); push(8'hFF, 0); push(8'hFF, 0);
    push(8'hFF, 0); push(8'h00, 0);
    for (int i = 0; i < 4; i++) push(8'hFF, 0);
    push(8'hA5, 0); push(8'h3C, 0); push(8'h81, 1);
    wait_idle();
    exp = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hA5, 8'h3C, 8'h81};
    for (int i = 0; i < 8; i++) exp.push_back(8'hFF);
    check_stream("R6 R7 R5 raw stream", exp);
    check("R9 done_ok raw", done_ok, 1);
    check("R9 err raw", err_code, 0);
    check("R10 ready after run", cfg_ready, 0);
  endtask

  task automatic t_compressed();
    logic [7:0] exp[$];
    start_run(1, 1, 1, 4 * 8);
    push(8'h55, 0); push(8'hFF, 0); push(8'h20, 0); push(8'hFF, 0);
    push(8'h31, 0); push(8'h12, 0); push(8'hE7, 1);
    wait_idle();
    exp = '{8'hFF, 8'h20, 8'h12, 8'hE7};
    check_stream("R8 compressed stream", exp);
    check("R9 done_ok compressed", done_ok, 1);
  endtask

  task automatic t_done_missing();
    logic [7:0] exp[$];
    start_run(0, 1, 1, -1);
    for (int i = 0; i < 4; i++) push(8'hFF, i == 3);
    wait_idle();
    for (int i = 0; i < 12; i++) exp.push_back(8'hFF);
    check_stream("R7 header-only stream", exp);
    check("R9 err code 3", err_code, 3);
    check("R9 no done_ok", done_ok, 0);
  endtask

  task automatic t_restart();
    logic [7:0] exp[$];
    start_run(1, 1, 1, -1);
    push(8'hFF, 0); push(8'h3A, 0); push(8'h6B, 0);
    repeat (10) @(negedge clk);
    start_run(0, 1, 1, 13 * 8);
    check("R11 reset phase re-entered", tgt_reset_n, 0);
    check("R11 busy", busy, 1);
    for (int i = 0; i < 4; i++) push(8'hFF, 0);
    push(8'h07, 1);
    wait_idle();
    exp = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h07};
    for (int i = 0; i < 8; i++) exp.push_back(8'hFF);
    check_stream("R11 restarted stream", exp);
    check("R11 done_ok", done_ok, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_init_stuck_high();
    t_init_stuck_low();
    t_raw();
    t_compressed();
    t_done_missing();
    t_restart();
    summary();
    $finish;
  end
endmodule